// File: doc/BRIEF.md
# Vector CR-to-Integer Bit Packer

This unit runs a vectorised condition-field test over a vector of length VL and packs the one-bit answers into integer registers. It handles one element per clock. For each element it reads a 4-bit condition field. It compares every bit of that field with a selector bit and keeps only the bits enabled by a 4-bit enable pattern. It then reduces the kept terms to a single bit, using OR or AND. The field read for each element either walks upward from a base index or stays on the base index.

The answers are packed into integer destination registers in one of two ways. With a vector destination, a 2-bit packing code sets how many answers share one register: 1, 2, 4 or 8. Each register is written whole, with every bit above its answer slots cleared. With a scalar destination, all answers gather bit by bit into one register, which is written once with a bit-level write mask that covers only the VL answer bits.

An operation begins when `start` is pulsed while the unit is idle. The unit reads condition fields through a combinational read port. It issues register writes that carry an index, data and a bit strobe, and it raises `done` for one cycle when the operation is complete.

Top module: `crpack_top`

## Requirements
- R1: With `src_vec`=1, element i reads field `cr_base`+i, wrapping modulo the field count. With `src_vec`=0, every element reads `cr_base`.
- R2: Term j (j=0..3) is `en_pat[j] & (sel_pat[j] == cr_rdata[j])`. The element answer is the OR of the four terms when `any_sel`=1 and the AND of the four terms when `any_sel`=0.
- R3: With `dst_vec`=1 and `pack_code`=00, element i's answer is written to bit 0 of register `rt_base`+i. All other bits of that register are written as zero.
- R4: With `dst_vec`=1 and `pack_code` set to 01, 10 or 11, let k be 2, 4 or 8 respectively. Element i goes to register `rt_base`+i/k at bit i mod k. Register indices wrap modulo the register count.
- R5: Every vector-destination write has all 64 strobe bits set. Bits above the k answer slots are written as zero. Unused slots in a final partial register are also written as zero.
- R6: With `dst_vec`=0, `pack_code` has no effect. Element i's answer goes to bit i of register `rt_base`. A single write is made whose strobe covers exactly bits 0..VL-1, and whose data is zero outside those bits.
- R7: Each destination register is written exactly once. The write appears in the cycle after the element that fills the register's last slot, or after the final element if that comes first.
- R8: A start with VL=0 raises `done` in the next cycle, makes no writes and makes no field reads.
- R9: For VL>=1, `done` is high for exactly one cycle, and that cycle immediately follows the cycle of the final write.
- R10: While `busy` is high, `start` is ignored. The operands are captured only when a start is accepted.
- R11: After reset, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| vl | input | 7 | Vector length, 0..64 |
| src_vec | input | 1 | 1: field index advances per element |
| dst_vec | input | 1 | 1: vector destination with packing |
| any_sel | input | 1 | 1: OR reduction, 0: AND reduction |
| en_pat | input | 4 | Per-bit term enable |
| sel_pat | input | 4 | Per-bit value each field bit is compared with |
| pack_code | input | 2 | Answers per register: 00=1, 01=2, 10=4, 11=8 |
| cr_base | input | 7 | First condition field index |
| rt_base | input | 5 | First destination register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cr_raddr | output | 7 | Condition field read index |
| cr_rdata | input | 4 | Field contents, same-cycle response |
| wr_en | output | 1 | Register write valid |
| wr_idx | output | 5 | Register being written |
| wr_data | output | 64 | Write data |
| wr_strb | output | 64 | Bit-level write mask |

## Verification
The bench targets the following corner cases, each of which exposes a specific class of defect:
- **Final partial register.** With VL=7 and k=2, or VL=10 and k=4, the last register is only partly filled. A design that waits for a full register would never issue that write. A design that leaves stale accumulator bits would write nonzero upper slots.
- **Scalar destination.** The bench runs VL=64 and VL=3 with a nonzero packing code. A design that wrongly applies the packing code would split the answers across several registers. A design with a wrong strobe would claim or drop bits.
- **Index wrap and fixed field.** The bench wraps both the field index and the register index, and also runs with a fixed source field. Off-by-one stepping shows up as wrong answers.
- **VL=0, start during an operation, and changed operands.** The bench issues a VL=0 start, pulses start partway through an operation, and changes the operand pins mid-run. A design that fails these checks would write nothing yet hang, restart the loop, or pick up the new operands.

// File: rtl/crpack_pkg.sv
package crpack_pkg;

  typedef enum logic [1:0] {
    PK_ONE   = 2'b00,
    PK_TWO   = 2'b01,
    PK_FOUR  = 2'b10,
    PK_EIGHT = 2'b11
  } pack_e;

  // Answers per destination register; a scalar destination takes all of them.
  function automatic logic [6:0] slots_per_reg(input logic dvec, input pack_e code,
                                               input logic [6:0] scalar_slots);
    logic [6:0] k;
    if (!dvec) k = scalar_slots;
    else begin
      unique case (code)
        PK_ONE:   k = 7'd1;
        PK_TWO:   k = 7'd2;
        PK_FOUR:  k = 7'd4;
        default:  k = 7'd8;
      endcase
    end
    return k;
  endfunction

  // One masked-equality term.
  function automatic logic eq_term(input logic en, input logic sel, input logic bitv);
    return en & (sel == bitv);
  endfunction

endpackage

// File: rtl/crpack_reduce.sv
module crpack_reduce #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] en_pat,
  input  logic [FW-1:0] sel_pat,
  input  logic [FW-1:0] field,
  input  logic          any_sel,
  output logic          answer
);
  import crpack_pkg::*;

  logic [FW-1:0] terms;

  generate
    for (genvar j = 0; j < FW; j++) begin : g_term
      assign terms[j] = eq_term(en_pat[j], sel_pat[j], field[j]);
    end
  endgenerate

  assign answer = any_sel ? (|terms) : (&terms);
endmodule

// File: rtl/crpack_ctrl.sv
module crpack_ctrl #(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic [VLW-1:0] k_in,
  output logic           accept,
  output logic           run,
  output logic           fin,
  output logic           busy,
  output logic           done,
  output logic [VLW-1:0] idx,
  output logic [VLW-1:0] slot,
  output logic [VLW-1:0] reg_off,
  output logic [VLW-1:0] vl_q,
  output logic           elem_last,
  output logic           flush
);
  logic [VLW-1:0] k_q;

  assign busy      = run | fin;
  assign accept    = start & ~busy;
  assign elem_last = run & (idx == vl_q - VLW'(1));
  assign flush     = run & (elem_last | (slot == k_q - VLW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      fin     <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      slot    <= '0;
      reg_off <= '0;
      vl_q    <= '0;
      k_q     <= VLW'(1);
    end else if (accept) begin
      run     <= (vl_in != '0);
      fin     <= 1'b0;
      done    <= (vl_in == '0);
      idx     <= '0;
      slot    <= '0;
      reg_off <= '0;
      vl_q    <= vl_in;
      k_q     <= k_in;
    end else if (run) begin
      done <= 1'b0;
      idx  <= idx + VLW'(1);
      if (flush) begin
        slot    <= '0;
        reg_off <= reg_off + VLW'(1);
      end else begin
        slot <= slot + VLW'(1);
      end
      if (elem_last) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end else begin
      done <= fin;
      fin  <= 1'b0;
    end
  end
endmodule

// File: rtl/crpack_pack.sv
module crpack_pack #(
  parameter int XLEN = 64,
  parameter int VLW  = 7,
  parameter int RAW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            step,
  input  logic            flush,
  input  logic            answer,
  input  logic [VLW-1:0]  slot,
  input  logic [RAW-1:0]  reg_idx,
  input  logic [XLEN-1:0] strb_in,
  output logic            wr_en,
  output logic [RAW-1:0]  wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] wr_strb
);
  logic [XLEN-1:0] acc;
  logic [XLEN-1:0] merged;

  assign merged = acc | (XLEN'(answer) << slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      wr_en <= 1'b0;
      if (clear) begin
        acc <= '0;
      end else if (step) begin
        if (flush) begin
          acc     <= '0;
          wr_en   <= 1'b1;
          wr_idx  <= reg_idx;
          wr_data <= merged;
          wr_strb <= strb_in;
        end else begin
          acc <= merged;
        end
      end
    end
  end
endmodule

// File: rtl/crpack_top.sv
module crpack_top #(
  parameter int XLEN   = 64,
  parameter int FW     = 4,
  parameter int CRF_AW = 7,
  parameter int RAW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [$clog2(XLEN):0] vl,
  input  logic              src_vec,
  input  logic              dst_vec,
  input  logic              any_sel,
  input  logic [FW-1:0]     en_pat,
  input  logic [FW-1:0]     sel_pat,
  input  logic [1:0]        pack_code,
  input  logic [CRF_AW-1:0] cr_base,
  input  logic [RAW-1:0]    rt_base,
  output logic              busy,
  output logic              done,
  output logic [CRF_AW-1:0] cr_raddr,
  input  logic [FW-1:0]     cr_rdata,
  output logic              wr_en,
  output logic [RAW-1:0]    wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   wr_strb
);
  import crpack_pkg::*;

  localparam int VLW = $clog2(XLEN) + 1;

  logic              accept, run, fin, elem_last, flush, answer;
  logic [VLW-1:0]    idx, slot, reg_off, vl_q, k_in;
  logic              src_vec_q, dst_vec_q, any_q;
  logic [FW-1:0]     en_q, sel_q;
  logic [CRF_AW-1:0] cr_base_q;
  logic [RAW-1:0]    rt_base_q;
  logic [XLEN-1:0]   strb_sel;
  logic [RAW-1:0]    reg_idx;

  assign k_in = slots_per_reg(dst_vec, pack_e'(pack_code), 7'(XLEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_vec_q <= 1'b0;
      dst_vec_q <= 1'b0;
      any_q     <= 1'b0;
      en_q      <= '0;
      sel_q     <= '0;
      cr_base_q <= '0;
      rt_base_q <= '0;
    end else if (accept) begin
      src_vec_q <= src_vec;
      dst_vec_q <= dst_vec;
      any_q     <= any_sel;
      en_q      <= en_pat;
      sel_q     <= sel_pat;
      cr_base_q <= cr_base;
      rt_base_q <= rt_base;
    end
  end

  crpack_ctrl #(.VLW(VLW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl), .k_in(k_in),
    .accept(accept), .run(run), .fin(fin), .busy(busy), .done(done),
    .idx(idx), .slot(slot), .reg_off(reg_off), .vl_q(vl_q),
    .elem_last(elem_last), .flush(flush)
  );

  assign cr_raddr = src_vec_q ? (cr_base_q + CRF_AW'(idx)) : cr_base_q;

  crpack_reduce #(.FW(FW)) red_i (
    .en_pat(en_q), .sel_pat(sel_q), .field(cr_rdata),
    .any_sel(any_q), .answer(answer)
  );

  always_comb begin
    for (int b = 0; b < XLEN; b++) begin
      strb_sel[b] = dst_vec_q | (b < int'(vl_q));
    end
  end

  assign reg_idx = rt_base_q + RAW'(reg_off);

  crpack_pack #(.XLEN(XLEN), .VLW(VLW), .RAW(RAW)) pack_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(run), .flush(flush),
    .answer(answer), .slot(slot), .reg_idx(reg_idx), .strb_in(strb_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
  );
endmodule

// File: rtl/crpack_chk.sv
module crpack_chk #(
  parameter int XLEN   = 64,
  parameter int CRF_AW = 7,
  parameter int VLW    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              run,
  input logic              src_vec_q,
  input logic              dst_vec_q,
  input logic [VLW-1:0]    vl_q,
  input logic [CRF_AW-1:0] cr_raddr,
  input logic              wr_en,
  input logic [XLEN-1:0]   wr_data,
  input logic [XLEN-1:0]   wr_strb
);
  // R1: fixed source field holds still across consecutive elements
  p_fixed_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !src_vec_q |-> $stable(cr_raddr));

  // R1: vector source field advances by one per element
  p_step_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && src_vec_q |-> cr_raddr == $past(cr_raddr) + CRF_AW'(1));

  // R5: vector-destination writes cover the full register
  p_full_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && dst_vec_q |-> &wr_strb);

  // R6: written data never sets a bit the strobe leaves out
  p_data_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data & ~wr_strb) == '0);

  // R7: a write only follows a processed element
  p_write_after_elem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(run));

  // R9: done is a single-cycle pulse with no write alongside it
  p_done_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en && !busy);

  // R10: operand length is held while the loop runs
  p_hold_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable(vl_q));

  // R10: a start seen while busy does not restart the loop
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && run |=> busy);
endmodule

bind crpack_top crpack_chk #(.XLEN(XLEN), .CRF_AW(CRF_AW), .VLW($clog2(XLEN) + 1)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .run(run),
  .src_vec_q(src_vec_q), .dst_vec_q(dst_vec_q), .vl_q(vl_q), .cr_raddr(cr_raddr),
  .wr_en(wr_en), .wr_data(wr_data), .wr_strb(wr_strb)
);

// File: tb/crpack_top_tb_top.sv
`timescale 1ns/1ps
module crpack_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [6:0]  vl = 0;
  logic        src_vec = 0, dst_vec = 0, any_sel = 0;
  logic [3:0]  en_pat = 0, sel_pat = 0;
  logic [1:0]  pack_code = 0;
  logic [6:0]  cr_base = 0;
  logic [4:0]  rt_base = 0;
  logic        busy, done, wr_en;
  logic [6:0]  cr_raddr;
  logic [3:0]  cr_rdata;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data, wr_strb;

  logic [3:0]  crmem [128];
  int checks = 0, bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  assign cr_rdata = crmem[cr_raddr];

  crpack_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .src_vec(src_vec),
    .dst_vec(dst_vec), .any_sel(any_sel), .en_pat(en_pat), .sel_pat(sel_pat),
    .pack_code(pack_code), .cr_base(cr_base), .rt_base(rt_base), .busy(busy),
    .done(done), .cr_raddr(cr_raddr), .cr_rdata(cr_rdata), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: answer of one element
  function automatic bit ref_answer(input logic [3:0] f, input logic [3:0] en,
                                    input logic [3:0] sel, input bit any);
    int hits = 0, enabled_eq = 0;
    for (int j = 0; j < 4; j++) if (en[j] && sel[j] == f[j]) hits++;
    enabled_eq = hits;
    return any ? (enabled_eq > 0) : (enabled_eq == 4);
  endfunction

  // Runs one operation and compares every cycle against a precomputed schedule.
  task automatic run_op(input int n, input bit sv, input bit dv, input bit any,
                        input logic [3:0] en, input logic [3:0] sel, input int code,
                        input int cb, input int rb, input bit poke, input string tag);
    bit          e_we   [0:70];
    int          e_idx  [0:70];
    logic [63:0] e_data [0:70];
    logic [63:0] e_strb [0:70];
    int k, donec, last;
    for (int c = 0; c <= 70; c++) begin
      e_we[c] = 0; e_idx[c] = 0; e_data[c] = 0; e_strb[c] = 0;
    end
    k = dv ? (1 << code) : 64;
    for (int i = 0; i < n; i++) begin
      int f = sv ? (cb + i) % 128 : cb;
      bit a = ref_answer(crmem[f], en, sel, any);
      int r = i / k;
      int wc = ((r + 1) * k < n) ? (r + 1) * k : n;   // cycle after the filling element
      e_we[wc] = 1;
      e_idx[wc] = dv ? (rb + r) % 32 : rb;
      e_data[wc][i % k] = a;
      e_strb[wc] = dv ? '1 : ((n == 64) ? '1 : ((64'd1 << n) - 1));
    end
    donec = (n == 0) ? 0 : n + 1;
    last  = donec + 2;
    @(negedge clk);
    start = 1; vl = 7'(n); src_vec = sv; dst_vec = dv; any_sel = any;
    en_pat = en; sel_pat = sel; pack_code = 2'(code); cr_base = 7'(cb); rt_base = 5'(rb);
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      start = 0;
      if (poke && c == 1) begin
        start = 1; vl = 7'd3; en_pat = ~en; any_sel = ~any; rt_base = 5'(rb + 9);
      end
      // R7/R8: write presence every cycle; R9: done pulse position
      chk(wr_en == e_we[c], $sformatf("R7 %s wr_en c=%0d", tag, c), 64'(wr_en), 64'(e_we[c]));
      chk(done == (c == donec), $sformatf("R9 %s done c=%0d", tag, c), 64'(done), 64'(c == donec));
      if (wr_en && e_we[c]) begin
        chk(wr_idx == 5'(e_idx[c]), $sformatf("R4 %s wr_idx c=%0d", tag, c), 64'(wr_idx), 64'(e_idx[c]));
        chk(wr_data == e_data[c], $sformatf("R2/R3 %s wr_data c=%0d", tag, c), wr_data, e_data[c]);
        chk(wr_strb == e_strb[c], $sformatf("R5/R6 %s wr_strb c=%0d", tag, c), wr_strb, e_strb[c]);
      end
    end
    chk(busy == 0, $sformatf("R10 %s idle after op", tag), 64'(busy), 64'd0);
  endtask

  initial begin
    for (int f = 0; f < 128; f++) crmem[f] = 4'((f * 7 + 3) ^ (f >> 3));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 0, "R11 busy", 64'(busy), 0);
    chk(done == 0, "R11 done", 64'(done), 0);
    chk(wr_en == 0, "R11 wr_en", 64'(wr_en), 0);
    rst_n = 1;
    @(negedge clk);
    // R3 one per register, OR reduction, stepping source (R1)
    run_op(5, 1, 1, 1, 4'b1011, 4'b0110, 0, 2, 4, 0, "k1");
    // R4/R5 pairs with AND reduction, partial final register
    run_op(7, 1, 1, 0, 4'b0011, 4'b0001, 1, 10, 0, 0, "k2");
    // R1 fixed source, quads, partial
    run_op(10, 0, 1, 1, 4'b1100, 4'b1000, 2, 33, 8, 0, "k4");
    // R4 octets
    run_op(20, 1, 1, 1, 4'b1111, 4'b0101, 3, 50, 12, 0, "k8");
    // R6 scalar full length
    run_op(64, 1, 0, 1, 4'b0110, 4'b0010, 0, 0, 7, 0, "scal64");
    // R6 scalar short, packing code ignored
    run_op(3, 1, 0, 0, 4'b0000, 4'b0000, 3, 20, 3, 0, "scal3");
    // R8 zero length
    run_op(0, 1, 1, 1, 4'b1111, 4'b1111, 0, 0, 0, 0, "vl0");
    // R10 start and operand changes during the run are ignored
    run_op(9, 1, 1, 1, 4'b1001, 4'b0001, 1, 70, 2, 1, "poke");
    // R1/R4 wrap of field and register index
    run_op(6, 1, 1, 0, 4'b0101, 4'b0100, 0, 125, 30, 0, "wrap");
    summary();
  end
endmodule